// File: doc/BRIEF.md
# Parallel NOR Flash Identification Probe

This block performs the power-up identification pass on a 16-bit-wide parallel NOR flash. After one `start` pulse it works through a fixed list of fifteen bus accesses. It unlocks the device and enters query mode, then reads the two version bytes of the vendor command table. Next it returns the device to read-array mode and enters autoselect mode. There it reads the manufacturer code and the device code. Finally it enters query mode once more and returns the device to read-array mode. The four bytes it collects are held on output registers, and a one-cycle strobe marks the point at which all four are present.

Every address the block issues is a word index multiplied by a scale factor and added to a base address. The scale factor is the interleave count times the device width in bytes. The command table is found at one of two word offsets, and `use_primary` picks which one. Only a 16-bit device is supported. Any other device width ends the probe at once: the block raises an error flag and makes no bus access.

The bus side is a plain request/acknowledge master. An access is presented while `bus_req` is high, and it completes on the clock edge where `bus_ack` is high.

Top module: `flash_id_probe`

## Requirements
- R1: After reset `busy`, `bus_req`, `id_valid` and `id_error` are 0, and the four result bytes are 0x00.
- R2: A `start` that arrives while idle with `cfg_dev_width` = 2 begins a run of exactly 15 accesses, in this order: writes AA, 55, 98; reads of version major and minor; writes F0, AA, 55, 90; reads of manufacturer and device codes; writes AA, 55, 98, F0. A write places its command byte in `bus_wdata[7:0]` and zeros in the upper bits.
- R3: Each command write goes to `base + U*F`. U is 0x5555 for the AA, 98, 90 and F0 commands, and 0x2AAA for the 55 command. F is `cfg_interleave * cfg_dev_width`. The sum is truncated to ADDR_W bits.
- R4: The version major byte is read at `base + (T+3)*F` and the minor byte at `base + (T+4)*F`. T is `prim_ofs` when `use_primary` = 1 and `alt_ofs` otherwise.
- R5: The manufacturer code is read at `base` and the device code at `base + F`. Each result byte is `bus_rdata` taken on the acknowledging edge of its read.
- R6: While `bus_req` is high and `bus_ack` is low, `bus_addr`, `bus_we` and `bus_wdata` hold their values into the next cycle.
- R7: `id_valid` is high for exactly one cycle per run: the cycle after the device-code read is acknowledged. All four result outputs hold the bytes of that run while it is high.
- R8: The last access of a run is the F0 write. `busy` drops in the cycle after that write is acknowledged.
- R9: A `start` that arrives while idle with `cfg_dev_width` other than 2 sets `id_error` in the next cycle and makes no bus access. `id_error` stays set until a `start` with width 2 clears it.
- R10: A `start` that arrives during a run is ignored. The base, table offset and scale factor are captured on the accepted `start`, and later changes to those inputs do not affect the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe when idle |
| use_primary | input | 1 | 1 selects prim_ofs, 0 selects alt_ofs |
| base_addr | input | ADDR_W | Device base address |
| prim_ofs | input | OFS_W | Primary table word offset |
| alt_ofs | input | OFS_W | Alternate table word offset |
| cfg_interleave | input | 3 | Number of interleaved devices |
| cfg_dev_width | input | 3 | Device width in bytes (only 2 accepted) |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Access completes on this edge |
| bus_rdata | input | 8 | Read data low byte |
| busy | output | 1 | Probe in progress |
| id_valid | output | 1 | One-cycle strobe: all four bytes captured |
| id_error | output | 1 | Unsupported device width |
| tbl_major | output | 8 | Table version major byte |
| tbl_minor | output | 8 | Table version minor byte |
| mfr_code | output | 8 | Manufacturer code |
| dev_code | output | 8 | Device code |

## Verification
If the step counter slips or skips, the effect shows up at the ports on the very next acknowledged access. That access carries the wrong command byte or the wrong address, and the bench compares each access against its own step list. An error in the scale factor or in the offset selection shows up as a wrong read address, and the captured byte then comes back different from what the flash model returns. A fault in the valid or completion logic moves the strobe or the fall of `busy` by at least one cycle, relative to the count of acknowledged accesses.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

    localparam int NUM_STEPS = 15;
    localparam int STEP_W    = $clog2(NUM_STEPS + 1);

    localparam logic [15:0] UNLK_A = 16'h5555;
    localparam logic [15:0] UNLK_B = 16'h2AAA;

    localparam logic [7:0] CMD_KEY1    = 8'hAA;
    localparam logic [7:0] CMD_KEY2    = 8'h55;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_AUTOSEL = 8'h90;
    localparam logic [7:0] CMD_RDARRAY = 8'hF0;

    localparam logic [2:0] WIDTH_X16 = 3'd2;

    typedef enum logic [2:0] {
        SEL_UNLK_A, SEL_UNLK_B, SEL_VMAJ, SEL_VMIN, SEL_MFR, SEL_DEV
    } addr_sel_e;

    typedef enum logic [2:0] {
        CAP_NONE, CAP_MAJ, CAP_MIN, CAP_MFR, CAP_DEV
    } cap_e;

    typedef struct packed {
        logic      we;
        addr_sel_e sel;
        logic [7:0] cmd;
        cap_e      cap;
    } step_t;

    function automatic step_t wr_step(input logic [7:0] c, input addr_sel_e s);
        step_t r;
        r.we = 1'b1; r.sel = s; r.cmd = c; r.cap = CAP_NONE;
        return r;
    endfunction

    function automatic step_t rd_step(input addr_sel_e s, input cap_e k);
        step_t r;
        r.we = 1'b0; r.sel = s; r.cmd = 8'h00; r.cap = k;
        return r;
    endfunction

    // Fixed probe program: query entry, version reads, reset,
    // autoselect entry, code reads, query re-entry, final reset.
    function automatic step_t step_lookup(input logic [STEP_W-1:0] idx);
        case (idx)
            4'd0:  return wr_step(CMD_KEY1,    SEL_UNLK_A);
            4'd1:  return wr_step(CMD_KEY2,    SEL_UNLK_B);
            4'd2:  return wr_step(CMD_QUERY,   SEL_UNLK_A);
            4'd3:  return rd_step(SEL_VMAJ, CAP_MAJ);
            4'd4:  return rd_step(SEL_VMIN, CAP_MIN);
            4'd5:  return wr_step(CMD_RDARRAY, SEL_UNLK_A);
            4'd6:  return wr_step(CMD_KEY1,    SEL_UNLK_A);
            4'd7:  return wr_step(CMD_KEY2,    SEL_UNLK_B);
            4'd8:  return wr_step(CMD_AUTOSEL, SEL_UNLK_A);
            4'd9:  return rd_step(SEL_MFR, CAP_MFR);
            4'd10: return rd_step(SEL_DEV, CAP_DEV);
            4'd11: return wr_step(CMD_KEY1,    SEL_UNLK_A);
            4'd12: return wr_step(CMD_KEY2,    SEL_UNLK_B);
            4'd13: return wr_step(CMD_QUERY,   SEL_UNLK_A);
            default: return wr_step(CMD_RDARRAY, SEL_UNLK_A);
        endcase
    endfunction

endpackage

// File: rtl/fprobe_addr_gen.sv
module fprobe_addr_gen
    import flash_probe_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  tbl_ofs,
    input  logic [5:0]        factor,
    input  addr_sel_e         sel,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] word_idx;

    always_comb begin
        case (sel)
            SEL_UNLK_A: word_idx = ADDR_W'(UNLK_A);
            SEL_UNLK_B: word_idx = ADDR_W'(UNLK_B);
            SEL_VMAJ:   word_idx = ADDR_W'(tbl_ofs) + ADDR_W'(3);
            SEL_VMIN:   word_idx = ADDR_W'(tbl_ofs) + ADDR_W'(4);
            SEL_DEV:    word_idx = ADDR_W'(1);
            default:    word_idx = '0;
        endcase
        addr = base + word_idx * ADDR_W'(factor);
    end
endmodule

// File: rtl/fprobe_seq.sv
module fprobe_seq
    import flash_probe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        dev_width,
    input  logic              bus_ack,
    output logic              busy,
    output logic [STEP_W-1:0] step_idx,
    output logic              launch,
    output logic              err
);
    typedef struct packed {
        logic              run;
        logic [STEP_W-1:0] step;
        logic              err;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        launch = 1'b0;
        if (!s_q.run) begin
            if (start) begin
                if (dev_width == WIDTH_X16) begin
                    s_d.run  = 1'b1;
                    s_d.step = '0;
                    s_d.err  = 1'b0;
                    launch   = 1'b1;
                end else begin
                    s_d.err = 1'b1;
                end
            end
        end else if (bus_ack) begin
            if (s_q.step == STEP_W'(NUM_STEPS - 1)) begin
                s_d.run  = 1'b0;
                s_d.step = '0;
            end else begin
                s_d.step = s_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.run;
    assign step_idx = s_q.step;
    assign err      = s_q.err;
endmodule

// File: rtl/fprobe_regs.sv
module fprobe_regs
    import flash_probe_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [OFS_W-1:0]  ofs_in,
    input  logic [5:0]        fact_in,
    input  cap_e              cap,
    input  logic              bus_ack,
    input  logic [7:0]        rdata,
    output logic [ADDR_W-1:0] base_q,
    output logic [OFS_W-1:0]  ofs_q,
    output logic [5:0]        fact_q,
    output logic [7:0]        maj_q,
    output logic [7:0]        min_q,
    output logic [7:0]        mfr_q,
    output logic [7:0]        dev_q,
    output logic              valid_q
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [OFS_W-1:0]  ofs;
        logic [5:0]        fact;
        logic [7:0]        maj;
        logic [7:0]        min;
        logic [7:0]        mfr;
        logic [7:0]        dev;
        logic              valid;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (launch) begin
            r_d.base = base_in;
            r_d.ofs  = ofs_in;
            r_d.fact = fact_in;
        end
        if (bus_ack) begin
            case (cap)
                CAP_MAJ: r_d.maj = rdata;
                CAP_MIN: r_d.min = rdata;
                CAP_MFR: r_d.mfr = rdata;
                CAP_DEV: begin
                    r_d.dev   = rdata;
                    r_d.valid = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign base_q  = r_q.base;
    assign ofs_q   = r_q.ofs;
    assign fact_q  = r_q.fact;
    assign maj_q   = r_q.maj;
    assign min_q   = r_q.min;
    assign mfr_q   = r_q.mfr;
    assign dev_q   = r_q.dev;
    assign valid_q = r_q.valid;
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
    import flash_probe_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              use_primary,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFS_W-1:0]  prim_ofs,
    input  logic [OFS_W-1:0]  alt_ofs,
    input  logic [2:0]        cfg_interleave,
    input  logic [2:0]        cfg_dev_width,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata,
    output logic              busy,
    output logic              id_valid,
    output logic              id_error,
    output logic [7:0]        tbl_major,
    output logic [7:0]        tbl_minor,
    output logic [7:0]        mfr_code,
    output logic [7:0]        dev_code
);
    localparam int PAD_W = DATA_W - 8;

    logic [STEP_W-1:0] step_idx;
    logic              launch;
    step_t             cur;
    cap_e              cap_now;
    logic [ADDR_W-1:0] base_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [5:0]        fact_q;
    logic [5:0]        fact_in;
    logic [OFS_W-1:0]  ofs_in;

    fprobe_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dev_width (cfg_dev_width),
        .bus_ack   (bus_ack),
        .busy      (busy),
        .step_idx  (step_idx),
        .launch    (launch),
        .err       (id_error)
    );

    always_comb begin
        cur     = step_lookup(step_idx);
        cap_now = busy ? cur.cap : CAP_NONE;
        fact_in = 6'(cfg_interleave) * 6'(cfg_dev_width);
        ofs_in  = use_primary ? prim_ofs : alt_ofs;
    end

    fprobe_regs #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .base_in (base_addr),
        .ofs_in  (ofs_in),
        .fact_in (fact_in),
        .cap     (cap_now),
        .bus_ack (bus_ack),
        .rdata   (bus_rdata),
        .base_q  (base_q),
        .ofs_q   (ofs_q),
        .fact_q  (fact_q),
        .maj_q   (tbl_major),
        .min_q   (tbl_minor),
        .mfr_q   (mfr_code),
        .dev_q   (dev_code),
        .valid_q (id_valid)
    );

    fprobe_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) agen_i (
        .base    (base_q),
        .tbl_ofs (ofs_q),
        .factor  (fact_q),
        .sel     (cur.sel),
        .addr    (bus_addr)
    );

    assign bus_req   = busy;
    assign bus_we    = cur.we;
    assign bus_wdata = cur.we ? {{PAD_W{1'b0}}, cur.cmd} : '0;
endmodule

// File: rtl/fprobe_chk.sv
module fprobe_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        cfg_dev_width,
    input logic              busy,
    input logic              id_valid,
    input logic              id_error,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata
);
    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cfg_dev_width == 3'd2) |=>
            (busy && bus_we && bus_wdata[7:0] == 8'hAA));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> !id_valid);

    p_valid_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> $past(bus_ack && bus_req && !bus_we));

    p_last_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bus_ack && bus_we && bus_wdata[7:0] == 8'hF0));

    p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cfg_dev_width != 3'd2) |=> (id_error && !busy));

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        id_error |-> !bus_req);
endmodule

bind flash_id_probe fprobe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cfg_dev_width (cfg_dev_width),
    .busy          (busy),
    .id_valid      (id_valid),
    .id_error      (id_error),
    .bus_req       (bus_req),
    .bus_ack       (bus_ack),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata)
);

// File: tb/flash_id_probe_tb.sv
`timescale 1ns/1ps
module flash_id_probe_tb_top;
    localparam int ADDR_W = 24;
    localparam int OFS_W  = 16;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic use_primary = 1'b1;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [OFS_W-1:0]  prim_ofs = '0;
    logic [OFS_W-1:0]  alt_ofs = '0;
    logic [2:0] cfg_interleave = 3'd1;
    logic [2:0] cfg_dev_width = 3'd2;
    logic bus_req, bus_we, bus_ack = 1'b0;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [7:0] bus_rdata = 8'h00;
    logic busy, id_valid, id_error;
    logic [7:0] tbl_major, tbl_minor, mfr_code, dev_code;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // access log filled by the flash model
    logic [ADDR_W-1:0] lg_addr [32];
    logic              lg_we   [32];
    logic [DATA_W-1:0] lg_data [32];
    int nacc = 0;
    int waitc = 0;
    int vcount = 0;
    int vlog = 0;
    logic [7:0] v_maj, v_min, v_mfr, v_dev;
    int last_ack_cyc = 0;
    int fall_cyc = 0;
    logic was_busy = 1'b0;
    logic pend = 1'b0;
    logic [ADDR_W-1:0] pend_addr;
    logic pend_we;
    logic [DATA_W-1:0] pend_data;
    int hold_bad = 0;

    always #2.5 clk = ~clk;

    flash_id_probe #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .use_primary(use_primary),
        .base_addr(base_addr), .prim_ofs(prim_ofs), .alt_ofs(alt_ofs),
        .cfg_interleave(cfg_interleave), .cfg_dev_width(cfg_dev_width),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .id_valid(id_valid), .id_error(id_error),
        .tbl_major(tbl_major), .tbl_minor(tbl_minor),
        .mfr_code(mfr_code), .dev_code(dev_code)
    );

    function automatic logic [7:0] flash_byte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    function automatic logic exp_we(input int k);
        return !(k == 3 || k == 4 || k == 9 || k == 10);
    endfunction

    function automatic logic [7:0] exp_cmd(input int k);
        case (k)
            0, 6, 11: return 8'hAA;
            1, 7, 12: return 8'h55;
            2, 13:    return 8'h98;
            8:        return 8'h90;
            5, 14:    return 8'hF0;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(input int k,
            input logic [ADDR_W-1:0] b, input logic [OFS_W-1:0] t, input int f);
        logic [ADDR_W-1:0] idx;
        case (k)
            1, 7, 12: idx = ADDR_W'(16'h2AAA);
            3:        idx = ADDR_W'(t) + 3;
            4:        idx = ADDR_W'(t) + 4;
            9:        idx = '0;
            10:       idx = 1;
            default:  idx = ADDR_W'(16'h5555);
        endcase
        return b + idx * ADDR_W'(f);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // flash model and monitors, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (id_valid) begin
            vcount++;
            vlog = nacc;
            v_maj = tbl_major; v_min = tbl_minor;
            v_mfr = mfr_code;  v_dev = dev_code;
        end
        if (was_busy && !busy) fall_cyc = cyc;
        was_busy = busy;
        if (pend && bus_req &&
            (bus_addr != pend_addr || bus_we != pend_we || bus_wdata != pend_data))
            hold_bad++;
        bus_ack = 1'b0;
        pend = 1'b0;
        if (bus_req) begin
            if (waitc == 0) begin
                if (nacc < 32) begin
                    lg_addr[nacc] = bus_addr;
                    lg_we[nacc]   = bus_we;
                    lg_data[nacc] = bus_wdata;
                end
                nacc++;
                last_ack_cyc = cyc;
                bus_rdata = flash_byte(bus_addr);
                bus_ack = 1'b1;
                waitc = int'($urandom % 4);
            end else begin
                waitc--;
                pend = 1'b1;
                pend_addr = bus_addr; pend_we = bus_we; pend_data = bus_wdata;
            end
        end
    end

    task automatic clear_log();
        nacc = 0; vcount = 0; vlog = -1; hold_bad = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_probe(input logic [ADDR_W-1:0] b, input logic [OFS_W-1:0] po,
                             input logic [OFS_W-1:0] ao, input logic up,
                             input logic [2:0] il, input bit disturb);
        int f;
        logic [OFS_W-1:0] t;
        int tmo;
        f = int'(il) * 2;
        t = up ? po : ao;
        base_addr = b; prim_ofs = po; alt_ofs = ao; use_primary = up;
        cfg_interleave = il; cfg_dev_width = 3'd2;
        clear_log();
        pulse_start();
        if (disturb) begin
            // R10: retrigger and change configuration mid-run
            @(negedge clk);
            base_addr = b ^ 24'h0F0F0F; prim_ofs = po + 16'h11; alt_ofs = ao + 16'h22;
            cfg_interleave = 3'd4; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        tmo = 0;
        while (busy && tmo < 2000) begin @(negedge clk); tmo++; end
        repeat (2) @(negedge clk);
        chk(nacc == 15, "R2", "access count", nacc, 15);
        for (int k = 0; k < 15 && k < nacc; k++) begin
            chk(lg_we[k] == exp_we(k), "R2", $sformatf("we step %0d", k), lg_we[k], exp_we(k));
            if (exp_we(k)) begin
                chk(lg_data[k] == {8'h00, exp_cmd(k)}, "R2", $sformatf("cmd step %0d", k),
                    lg_data[k], {8'h00, exp_cmd(k)});
                chk(lg_addr[k] == exp_addr(k, b, t, f), "R3", $sformatf("addr step %0d", k),
                    lg_addr[k], exp_addr(k, b, t, f));
            end else if (k < 5) begin
                chk(lg_addr[k] == exp_addr(k, b, t, f), "R4", $sformatf("addr step %0d", k),
                    lg_addr[k], exp_addr(k, b, t, f));
            end else begin
                chk(lg_addr[k] == exp_addr(k, b, t, f), "R5", $sformatf("addr step %0d", k),
                    lg_addr[k], exp_addr(k, b, t, f));
            end
        end
        chk(vcount == 1, "R7", "valid pulses", vcount, 1);
        chk(vlog == 11, "R7", "accesses before valid", vlog, 11);
        chk(v_maj == flash_byte(exp_addr(3, b, t, f)), "R4", "major", v_maj, flash_byte(exp_addr(3, b, t, f)));
        chk(v_min == flash_byte(exp_addr(4, b, t, f)), "R4", "minor", v_min, flash_byte(exp_addr(4, b, t, f)));
        chk(v_mfr == flash_byte(exp_addr(9, b, t, f)), "R5", "mfr", v_mfr, flash_byte(exp_addr(9, b, t, f)));
        chk(v_dev == flash_byte(exp_addr(10, b, t, f)), "R5", "dev", v_dev, flash_byte(exp_addr(10, b, t, f)));
        chk(fall_cyc == last_ack_cyc + 1, "R8", "busy fall cycle", fall_cyc, last_ack_cyc + 1);
        chk(hold_bad == 0, "R6", "held access changed", hold_bad, 0);
        chk(!id_error, "R9", "error after good run", id_error, 0);
    endtask

    task automatic reject(input logic [2:0] w);
        clear_log();
        cfg_dev_width = w;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(id_error == 1'b1 && busy == 1'b0, "R9", $sformatf("reject width %0d", w),
            {id_error, busy}, 2'b10);
        repeat (5) @(negedge clk);
        chk(nacc == 0, "R9", "no access on reject", nacc, 0);
        chk(id_error == 1'b1, "R9", "error held", id_error, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && !bus_req && !id_valid && !id_error, "R1", "control after reset",
            {busy, bus_req, id_valid, id_error}, 0);
        chk({tbl_major, tbl_minor, mfr_code, dev_code} == 32'h0, "R1", "results after reset",
            {tbl_major, tbl_minor, mfr_code, dev_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed: primary table, single device
        run_probe(24'h000000, 16'h0010, 16'h0040, 1'b1, 3'd1, 1'b0);
        // directed: alternate table, two interleaved
        run_probe(24'h100000, 16'h0010, 16'h0040, 1'b0, 3'd2, 1'b0);
        // directed: wraparound of the address sum
        run_probe(24'hFFFF00, 16'hFFFB, 16'h0000, 1'b1, 3'd4, 1'b0);
        // R10: retrigger and input changes during a run
        run_probe(24'h020000, 16'h0031, 16'h0007, 1'b1, 3'd2, 1'b1);
        // R9: rejected widths, then recovery
        reject(3'd1);
        reject(3'd4);
        run_probe(24'h004000, 16'h0020, 16'h0060, 1'b0, 3'd1, 1'b0);
        // random configurations
        for (int i = 0; i < 8; i++) begin
            logic [2:0] il;
            case ($urandom % 3) 0: il = 3'd1; 1: il = 3'd2; default: il = 3'd4; endcase
            run_probe(ADDR_W'($urandom), OFS_W'($urandom), OFS_W'($urandom),
                      1'($urandom), il, 1'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule